// File: doc/BRIEF.md
# Multi-Channel Match PWM Timer

This block produces six pulse-width modulated outputs from one shared up-counter. The counter advances once per prescale period. Seven compare channels, numbered 0 to 6, watch the counter. When a channel's compare value equals the counter on an advance, that channel can do any mix of three things: restart the counter at zero, halt counting, or raise an interrupt flag. Channel 0 is normally set to restart the counter, so its compare value sets the PWM period.

Each output, numbered 1 to 6, has two modes. In single-edge mode it rises when the counter restarts and falls at its own compare. In double-edge mode, output n rises at compare n-1 and falls at compare n. Software writes compare values into shadow registers. The active compare registers only take new values at a period boundary, and only for channels that software has armed.

Software reaches the block through a simple synchronous word-addressed bus. The read path is combinational. Writes take effect at the clock edge.

Top module: `pwm_match_timer`

## Requirements
- R1: After reset, every register reads zero. This covers the flag word (address 0), the control word (address 1), the output setup word (address 4) and the arm word (address 5). All PWM outputs and the interrupt line are low.
- R2: Address 2 holds the prescale limit P. While the enable bit (address 1, bit 0) is 1, the counter (read at address 7) advances once every P+1 clocks. While the enable bit is 0, the counter holds its value.
- R3: While the clear bit (address 1, bit 1) is 1, the counter and the prescaler stay at zero, whatever the enable bit holds.
- R4: Address 3 holds the action bits: bit 3k enables the interrupt for channel k, bit 3k+1 restarts the counter and bit 3k+2 halts it. On an advance where the counter equals the compare value of a channel whose restart bit is set, the next counter value is 0.
- R5: On an advance where the counter matches a channel whose halt bit is set, the enable bit clears and the counter keeps its current value.
- R6: On a match, a channel whose interrupt bit is set raises its flag. Channels 0 to 3 show at bits 0 to 3 of address 0, and channels 4 to 6 at bits 8 to 10. The interrupt output is high whenever any flag is set. A new match wins over a clear that lands in the same cycle.
- R7: Writing 1 to a flag bit at address 0 clears that flag. Writing 0 leaves the flag unchanged.
- R8: A value written to addresses 8+k goes into the shadow register of channel k. It moves into the active compare only when channel 0 restarts the counter while arm bit k (address 5) is set. After that transfer, all arm bits read 0.
- R9: Single-edge output n goes high when a match restarts the counter and goes low on a match of channel n. When both happen together, low wins.
- R10: Bit n of address 4 (n = 2..6) puts output n in double-edge mode. In that mode the output goes high on a match of channel n-1 and low on a match of channel n, and low wins when both happen together. Bit 1 is ignored and reads 0, so output 1 is always single-edge.
- R11: Bit 8+n of address 4 enables output n. A disabled output is held low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on bus_addr |
| pwm_o | output | 6 | PWM outputs 1 to 6 |
| irq_o | output | 1 | OR of all interrupt flags |

## Verification
The halt and arm assertions assume that software does not rewrite the control word or the arm word in the same cycle as a halting or restarting match. In that case the bus write takes priority and the property would not hold. The stimulus meets this in two ways. It writes the control word only while the counter is held clear, stopped, or far from a halting compare. It writes the arm word only when the next restart is several cycles away. Compare values are changed only through the shadow registers, so the active compares change only at period boundaries, where the waveform checks expect it.

// File: rtl/pwm_match_timer.sv
module pwm_match_timer #(
  parameter int CW = 16,
  parameter int PW = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic [6:1]  pwm_o,
  output logic        irq_o
);
  localparam int NM = 7;

  logic [CW-1:0]   tc;
  logic [CW-1:0]   mr [NM];
  logic [CW-1:0]   sh [NM];
  logic [PW-1:0]   pc, pr;
  logic            run_en, cnt_clr;
  logic [3*NM-1:0] mcr;
  logic [6:2]      dbl;
  logic [6:1]      oen, q, set_v;
  logic [NM-1:0]   le, flg, hit, hit_int, hit_rst, hit_stop;

  wire run  = run_en & ~cnt_clr;
  wire tick = run && (pc == pr);

  always_comb
    for (int k = 0; k < NM; k++) begin
      hit[k]      = tick && (tc == mr[k]);
      hit_int[k]  = hit[k] & mcr[3*k];
      hit_rst[k]  = hit[k] & mcr[3*k+1];
      hit_stop[k] = hit[k] & mcr[3*k+2];
    end

  wire tc_rst = |hit_rst;
  wire stop   = |hit_stop;
  wire load   = hit_rst[0];

  wire wr_ir  = bus_wr && bus_addr == 4'd0;
  wire wr_tcr = bus_wr && bus_addr == 4'd1;
  wire wr_pr  = bus_wr && bus_addr == 4'd2;
  wire wr_mcr = bus_wr && bus_addr == 4'd3;
  wire wr_oc  = bus_wr && bus_addr == 4'd4;
  wire wr_le  = bus_wr && bus_addr == 4'd5;
  wire wr_mr  = bus_wr && bus_addr[3] && bus_addr[2:0] != 3'd7;
  wire [NM-1:0] w1c = wr_ir ? {bus_wdata[10:8], bus_wdata[3:0]} : '0;

  always_ff @(posedge clk)
    if (!rst_n) begin
      tc <= '0;
      pc <= '0;
    end else if (cnt_clr) begin
      tc <= '0;
      pc <= '0;
    end else if (tick) begin
      pc <= '0;
      tc <= tc_rst ? '0 : stop ? tc : tc + 1'b1;
    end else if (run) begin
      pc <= pc + 1'b1;
    end

  always_ff @(posedge clk)
    if (!rst_n) begin
      run_en <= 1'b0; cnt_clr <= 1'b0;
      pr <= '0; mcr <= '0; dbl <= '0; oen <= '0; le <= '0; flg <= '0;
    end else begin
      if (wr_tcr) {cnt_clr, run_en} <= bus_wdata[1:0];
      else if (stop) run_en <= 1'b0;
      if (wr_pr) pr <= bus_wdata[PW-1:0];
      if (wr_mcr) mcr <= bus_wdata[3*NM-1:0];
      if (wr_oc) begin
        dbl <= bus_wdata[6:2];
        oen <= bus_wdata[14:9];
      end
      if (wr_le) le <= bus_wdata[NM-1:0];
      else if (load) le <= '0;
      flg <= (flg & ~w1c) | hit_int;
    end

  always_ff @(posedge clk)
    for (int k = 0; k < NM; k++)
      if (!rst_n) begin
        sh[k] <= '0;
        mr[k] <= '0;
      end else begin
        if (wr_mr && bus_addr[2:0] == 3'(k)) sh[k] <= bus_wdata[CW-1:0];
        if (load && le[k]) mr[k] <= sh[k];
      end

  for (genvar n = 1; n <= 6; n++) begin : g_out
    if (n == 1) begin : g_se
      assign set_v[n] = tc_rst;
    end else begin : g_sel
      assign set_v[n] = dbl[n] ? hit[n-1] : tc_rst;
    end
    AST_MATCH_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
      hit[n] |=> !q[n]);                                                   // R9
  end

  always_ff @(posedge clk)
    if (!rst_n) q <= '0;
    else q <= (q | set_v) & ~hit[6:1];

  assign pwm_o = q & oen;
  assign irq_o = |flg;

  always_comb
    case (bus_addr)
      4'd0:    bus_rdata = {21'b0, flg[6:4], 4'b0, flg[3:0]};
      4'd1:    bus_rdata = {30'b0, cnt_clr, run_en};
      4'd2:    bus_rdata = 32'(pr);
      4'd3:    bus_rdata = {11'b0, mcr};
      4'd4:    bus_rdata = {17'b0, oen, 2'b0, dbl, 2'b0};
      4'd5:    bus_rdata = {25'b0, le};
      4'd7:    bus_rdata = 32'(tc);
      4'd8, 4'd9, 4'd10, 4'd11, 4'd12, 4'd13, 4'd14:
               bus_rdata = 32'(sh[bus_addr[2:0]]);
      default: bus_rdata = '0;
    endcase

  AST_CLEAR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (tc == '0 && pc == '0));                                   // R3
  AST_COUNT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_clr) |=> $stable(tc));                                  // R2
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    tc_rst |=> tc == '0);                                                  // R4
  AST_HALT_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !wr_tcr) |=> !run_en);                                        // R5
  AST_FLAG_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit_int) |=> irq_o);                                                 // R6
  AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !wr_le) |=> le == '0);                                        // R8
  for (genvar k = 0; k < NM; k++) begin : g_ld
    AST_SHADOW_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
      (load && le[k]) |=> mr[k] == $past(sh[k]));                          // R8
  end
endmodule

// File: tb/sim_pwm_match_timer.sv
`timescale 1ns/1ps
module sim_pwm_match_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [6:1]  pwm_o;
  logic        irq_o;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwm_match_timer u0 (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_o(pwm_o), .irq_o(irq_o));

  // {double, m1, m2, expected high clocks per 10-clock period}, output 2
  localparam logic [31:0] VEC [8] = '{
    32'h00_00_03_04, 32'h00_00_06_07, 32'h00_00_0C_0A, 32'h01_02_07_05,
    32'h01_07_02_05, 32'h01_04_04_00, 32'h00_00_09_00, 32'h00_00_00_01};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output int d);
    @(negedge clk);
    bus_addr = a;
    #1 d = int'(bus_rdata);
  endtask

  task automatic count_hi(input int n, output int c);
    c = 0;
    repeat (10) begin
      @(negedge clk);
      if (pwm_o[n]) c++;
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    int d, c, t0, t1;
    wait_clk(3);
    rst_n = 1'b1;
    rd(4'd0, d); check("R1 flags", d, 0);
    rd(4'd1, d); check("R1 control", d, 0);
    rd(4'd4, d); check("R1 output setup", d, 0);
    rd(4'd5, d); check("R1 arm", d, 0);
    check("R1 outputs", {26'b0, pwm_o, irq_o}, 0);

    wr(4'd2, 0);
    wr(4'd3, 32'h2);
    for (int i = 0; i < 8; i++) begin
      wr(4'd1, 32'h2);
      wr(4'd8, 9);
      wr(4'd9, 32'(VEC[i][23:16]));
      wr(4'd10, 32'(VEC[i][15:8]));
      wr(4'd5, 32'h07);
      wr(4'd4, 32'h7E00 | (VEC[i][24] ? 32'h4 : 32'h0));
      wr(4'd1, 32'h1);
      wait_clk(40);
      count_hi(2, c);
      check(VEC[i][24] ? "R10 double-edge" : "R9 single-edge", c, int'(VEC[i][7:0]));
      rd(4'd7, d); check("R4 restart bounds count", int'(d < 10), 1);
    end

    wr(4'd10, 3); wr(4'd4, 32'h7E00); wr(4'd5, 32'h04);
    wait_clk(30); count_hi(2, c); check("R9 single m2=3", c, 4);
    wr(4'd10, 6);
    wait_clk(30); count_hi(2, c); check("R8 unarmed shadow ignored", c, 4);
    wr(4'd5, 32'h04);
    wait_clk(30); count_hi(2, c); check("R8 armed shadow applied", c, 7);
    rd(4'd5, d); check("R8 arm bits self-clear", d, 0);

    wr(4'd9, 5); wr(4'd4, 32'h7E02); wr(4'd5, 32'h02);
    wait_clk(30); count_hi(1, c); check("R10 output 1 stays single", c, 6);
    rd(4'd4, d); check("R10 bit 1 reads 0", d, 32'h7E00);
    wr(4'd4, 32'h7A00);
    wait_clk(2); count_hi(2, c); check("R11 disabled output low", c, 0);
    count_hi(1, c); check("R11 enabled output runs", c, 6);

    wr(4'd1, 32'h2);
    wr(4'd8, 20); wr(4'd11, 5); wr(4'd13, 4); wr(4'd5, 32'h29);
    wr(4'd1, 32'h1);
    wait_clk(15);
    wr(4'd3, 32'h2 | (1 << 9) | (1 << 11) | (1 << 15));
    wait_clk(50);
    rd(4'd1, d); check("R5 halt clears enable", d, 0);
    rd(4'd7, t0); wait_clk(5); rd(4'd7, t1);
    check("R5 count held", t0, 5); check("R5 count stable", t1, 5);
    rd(4'd0, d); check("R6 flag bits 3 and 9", d, 32'h208);
    check("R6 irq high", int'(irq_o), 1);
    wr(4'd0, 0); rd(4'd0, d); check("R7 write 0 no effect", d, 32'h208);
    wr(4'd0, 32'h8); rd(4'd0, d); check("R7 clear bit 3 only", d, 32'h200);
    check("R7 irq still high", int'(irq_o), 1);
    wr(4'd0, 32'h200); rd(4'd0, d); check("R7 all cleared", d, 0);
    check("R6 irq low with no flags", int'(irq_o), 0);

    wr(4'd1, 32'h2); wr(4'd3, 0); wr(4'd2, 3); wr(4'd1, 32'h1);
    wait_clk(3);
    rd(4'd7, t0); wait_clk(7); rd(4'd7, t1);
    check("R2 prescale 3 gives 2 counts in 8 clocks", t1 - t0, 2);
    wr(4'd1, 32'h0); rd(4'd7, t0); wait_clk(6); rd(4'd7, t1);
    check("R2 disabled holds", t1 - t0, 0);
    wr(4'd1, 32'h3); wait_clk(5);
    rd(4'd7, d); check("R3 clear holds zero", d, 0);
    wait_clk(9); rd(4'd7, d); check("R3 still zero", d, 0);

    done = 1'b1;
    summary();
  end
endmodule